// File: doc/BRIEF.md
# Nibble Accumulator Processor

A compact stored-program processor with a 4-bit accumulator and a single 8-bit internal bus. Every machine word is eight bits: an operation code in the upper four bits and a four-bit operand (a memory location or an immediate value) in the lower four. The core holds a program counter, a memory address latch, a sixteen-word program/data store, an instruction latch, the accumulator, a second operand latch, a display latch and two condition flags (carry, zero). A step counter sequences every instruction through three fetch steps followed by one to three execute steps, and in each step exactly one source, or none, drives the bus.

A program is placed in the store through a load port while reset is held. When reset is released, execution starts at location 0. Results leave the block only through the display latch, which is written by the output instruction, and through a halted indicator that is raised by the halt instruction.

Top module: `nib_cpu`

## Requirements
- R1: Word format is operation code in bits [7:4] and operand in bits [3:0]; codes: 0 no-op, 1 load from memory, 2 add, 3 subtract, 4 store, 5 load immediate, 6 jump, 7 jump on carry, 8 jump on zero, 9 AND, A OR, B XOR, E copy accumulator to display, F halt.
- R2: Each instruction takes three fetch steps plus its execute steps: 1 for codes 0, 5, 6, 7, 8, C, D, E, F; 2 for codes 1 and 4; 3 for codes 2, 3, 9, A, B. A program "5x, F0" raises halted after 8 clocks, "5x, 2y, F0" after 14 clocks.
- R3: Add gives (A+M) mod 16 with carry set when A+M > 15; subtract gives (A-M) mod 16 with carry set when A >= M; AND/OR/XOR give the bitwise result and clear carry; zero is set when the 4-bit result is 0. M is the low nibble of the addressed word.
- R4: Load immediate writes the operand into A without a memory read; only codes 2, 3, 9, A, B change the flags.
- R5: Store writes the word {0000, A} to the operand location; memory contents survive reset.
- R6: Jump loads the operand into the program counter; jump on carry and jump on zero do so only when their flag is 1, and otherwise fall through.
- R7: The program counter wraps from 15 to 0.
- R8: The display latch is cleared by reset and changes only on code E, which copies A.
- R9: After halt, no state visible at the ports changes until reset.
- R10: Codes 0, C and D leave A, the flags, memory and the program flow untouched.
- R11: The load port writes ld_data to location ld_addr only while reset is asserted; a write attempt with reset low has no effect.
- R12: Reset clears the program counter, step counter, A, B, the flags and halted; out_val reads 0 and halted reads 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the load port |
| ld_en | input | 1 | Load port write strobe |
| ld_addr | input | 4 | Load port location |
| ld_data | input | 8 | Load port word |
| out_val | output | 4 | Display latch |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The arithmetic and logic operations are swept over every pair of accumulator and memory nibbles, each pair run twice: once stopping right after the result is displayed, which exposes the value, and once through a jump-on-carry / jump-on-zero tree that displays a 2-bit flag code, which separates carry and zero faults from value faults and checks both branch senses. Directed programs then distinguish the remaining behaviours: store followed by a reset and a reload of the stored word, a jump over code that would otherwise display a different value, a program that runs through location 15 and wraps, reserved codes placed between a load and a display, and a write on the load port while running. Clock counts to halt tell apart fetch and execute step lengths per instruction class.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_LDA  = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_STA  = 4'h4,
    OP_LDI  = 4'h5,
    OP_JMP  = 4'h6,
    OP_JC   = 4'h7,
    OP_JZ   = 4'h8,
    OP_AND  = 4'h9,
    OP_OR   = 4'hA,
    OP_XOR  = 4'hB,
    OP_RSV0 = 4'hC,
    OP_RSV1 = 4'hD,
    OP_OUT  = 4'hE,
    OP_HLT  = 4'hF
  } opcode_e;

  // Who owns the shared bus in a given step
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_PC   = 3'd1,
    SRC_RAM  = 3'd2,
    SRC_IR   = 3'd3,
    SRC_ACC  = 3'd4,
    SRC_ALU  = 3'd5
  } bus_src_e;

  typedef struct packed {
    bus_src_e src;
    logic     mar_ld;
    logic     ir_ld;
    logic     a_ld;
    logic     b_ld;
    logic     out_ld;
    logic     ram_we;
    logic     pc_inc;
    logic     pc_ld;
    logic     flg_ld;
    logic     halt_set;
    logic     last;
  } ctrl_t;

  localparam int STEP_W = 3;

  function automatic logic is_alu_op(opcode_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/nib_cpu_ram.sv
module nib_cpu_ram #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // No reset: contents persist across processor reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu
  import nib_cpu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  // Returns {carry, result}
  function automatic logic [DATA_W:0] calc(opcode_e f, logic [DATA_W-1:0] x,
                                           logic [DATA_W-1:0] y);
    logic [DATA_W:0] r;
    case (f)
      OP_ADD:  r = {1'b0, x} + {1'b0, y};
      OP_SUB:  r = {1'b0, x} + {1'b0, ~y} + {{DATA_W{1'b0}}, 1'b1};
      OP_AND:  r = {1'b0, x & y};
      OP_OR:   r = {1'b0, x | y};
      OP_XOR:  r = {1'b0, x ^ y};
      default: r = '0;
    endcase
    return r;
  endfunction

  assign {cout, res} = calc(op, a, b);

endmodule

// File: rtl/nib_cpu_ctrl.sv
module nib_cpu_ctrl
  import nib_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  opcode_e           op,
  input  logic              flg_c,
  input  logic              flg_z,
  output ctrl_t             ctl,
  output logic [STEP_W-1:0] step,
  output logic              halted
);

  always_comb begin
    ctl = '0;
    if (!halted) begin
      case (step)
        3'd0: begin ctl.src = SRC_PC;  ctl.mar_ld = 1'b1; end
        3'd1: ctl.pc_inc = 1'b1;
        3'd2: begin ctl.src = SRC_RAM; ctl.ir_ld = 1'b1; end
        default: begin
          if (op == OP_LDA || op == OP_STA || is_alu_op(op)) begin
            if (step == 3'd3) begin
              ctl.src = SRC_IR;
              ctl.mar_ld = 1'b1;
            end else if (op == OP_LDA) begin
              ctl.src = SRC_RAM; ctl.a_ld = 1'b1; ctl.last = 1'b1;
            end else if (op == OP_STA) begin
              ctl.src = SRC_ACC; ctl.ram_we = 1'b1; ctl.last = 1'b1;
            end else if (step == 3'd4) begin
              ctl.src = SRC_RAM; ctl.b_ld = 1'b1;
            end else begin
              ctl.src = SRC_ALU; ctl.a_ld = 1'b1; ctl.flg_ld = 1'b1;
              ctl.last = 1'b1;
            end
          end else begin
            ctl.last = 1'b1;
            case (op)
              OP_LDI: begin ctl.src = SRC_IR; ctl.a_ld = 1'b1; end
              OP_JMP: begin ctl.src = SRC_IR; ctl.pc_ld = 1'b1; end
              OP_JC:  begin ctl.src = SRC_IR; ctl.pc_ld = flg_c; end
              OP_JZ:  begin ctl.src = SRC_IR; ctl.pc_ld = flg_z; end
              OP_OUT: begin ctl.src = SRC_ACC; ctl.out_ld = 1'b1; end
              OP_HLT: ctl.halt_set = 1'b1;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      step <= ctl.last ? '0 : step + 1'b1;
      if (ctl.halt_set) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_cpu_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4,
  localparam int INSN_W = 4 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [INSN_W-1:0] ld_data,
  output logic [DATA_W-1:0] out_val,
  output logic              halted
);

  localparam int BUS_W = INSN_W;

  ctrl_t             ctl;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] pc, mar;
  logic [INSN_W-1:0] ir;
  logic [DATA_W-1:0] acc, opb, alu_res;
  logic              flg_c, flg_z, alu_c;
  logic [BUS_W-1:0]  bus;
  logic [INSN_W-1:0] ram_q;
  opcode_e           cur_op;

  // Named events for the checker
  logic              pc_inc, pc_ld, out_ld;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [INSN_W-1:0] mem_wdata;

  assign cur_op = opcode_e'(ir[INSN_W-1 -: 4]);
  assign pc_inc = ctl.pc_inc;
  assign pc_ld  = ctl.pc_ld;
  assign out_ld = ctl.out_ld;

  nib_cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .op     (cur_op),
    .flg_c  (flg_c),
    .flg_z  (flg_z),
    .ctl    (ctl),
    .step   (step),
    .halted (halted)
  );

  nib_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (cur_op),
    .a    (acc),
    .b    (opb),
    .res  (alu_res),
    .cout (alu_c)
  );

  // Load port is live only under reset; the processor writes otherwise
  assign mem_we    = rst ? ld_en : ctl.ram_we;
  assign mem_waddr = rst ? ld_addr : mar;
  assign mem_wdata = rst ? ld_data : INSN_W'(bus);

  nib_cpu_ram #(.ADDR_W(ADDR_W), .WORD_W(INSN_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (ram_q)
  );

  // Single-driver bus; undriven reads as zero
  always_comb begin
    case (ctl.src)
      SRC_PC:  bus = BUS_W'(pc);
      SRC_RAM: bus = BUS_W'(ram_q);
      SRC_IR:  bus = BUS_W'(ir[ADDR_W-1:0]);
      SRC_ACC: bus = BUS_W'(acc);
      SRC_ALU: bus = BUS_W'(alu_res);
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      mar     <= '0;
      ir      <= '0;
      acc     <= '0;
      opb     <= '0;
      flg_c   <= 1'b0;
      flg_z   <= 1'b0;
      out_val <= '0;
    end else begin
      if (ctl.pc_ld)       pc <= bus[ADDR_W-1:0];
      else if (ctl.pc_inc) pc <= pc + 1'b1;
      if (ctl.mar_ld) mar     <= bus[ADDR_W-1:0];
      if (ctl.ir_ld)  ir      <= bus[INSN_W-1:0];
      if (ctl.a_ld)   acc     <= bus[DATA_W-1:0];
      if (ctl.b_ld)   opb     <= bus[DATA_W-1:0];
      if (ctl.out_ld) out_val <= bus[DATA_W-1:0];
      if (ctl.flg_ld) begin
        flg_c <= alu_c;
        flg_z <= (alu_res == '0);
      end
    end
  end

endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4,
  parameter int INSN_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [DATA_W-1:0] out_val,
  input logic              out_ld,
  input logic              pc_inc,
  input logic              pc_ld,
  input logic [ADDR_W-1:0] pc,
  input logic [INSN_W-1:0] ir,
  input logic [2:0]        step
);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r9_out_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(out_val));

  a_r8_out_only_on_out: assert property (@(posedge clk) disable iff (rst)
    !out_ld |=> $stable(out_val));

  a_r7_pc_wrap_inc: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_ld) |=> pc == ADDR_W'($past(pc) + 1'b1));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    pc_ld |=> pc == $past(ir[ADDR_W-1:0]));

  a_r2_step_bound: assert property (@(posedge clk) disable iff (rst)
    step <= 3'd5);

  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

endmodule

bind nib_cpu nib_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .halted  (halted),
  .out_val (out_val),
  .out_ld  (out_ld),
  .pc_inc  (pc_inc),
  .pc_ld   (pc_ld),
  .pc      (pc),
  .ir      (ir),
  .step    (step)
);

// File: tb/nib_cpu_bench.sv
module nib_cpu_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] out_val;
  logic       halted;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  nib_cpu u_nib_cpu (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .out_val (out_val),
    .halted  (halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic poke(input int a, input int d);
    ld_en = 1'b1; ld_addr = 4'(a); ld_data = 8'(d);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all(input logic [7:0] p [16]);
    for (int i = 0; i < 16; i++) poke(i, p[i]);
  endtask

  // Release reset and count clocks until halted
  task automatic run(output int cyc);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 200) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_res(input int op, input int a, input int b);
    case (op)
      2: return (a + b) % 16;
      3: return (a - b + 16) % 16;
      9: return a & b;
      10: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic int exp_code(input int op, input int a, input int b);
    int c;
    int z;
    c = 0;
    if (op == 2) c = (a + b > 15) ? 1 : 0;
    if (op == 3) c = (a >= b) ? 1 : 0;
    z = (exp_res(op, a, b) == 0) ? 1 : 0;
    return c * 2 + z;
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] p [16];
    int cyc;

    // R12: reset state
    @(negedge clk); @(negedge clk);
    chk("R12 out_val in reset", int'(out_val), 0);
    chk("R12 halted in reset", int'(halted), 0);

    // R2 / R8: LDI then HLT, display untouched
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h55; p[1] = 8'hF0;
    load_all(p);
    run(cyc);
    chk("R2 cycles LDI+HLT", cyc, 8);
    chk("R8 display untouched without OUT", int'(out_val), 0);
    chk("R12 halted after HLT", int'(halted), 1);

    // R2: ALU class takes 6 clocks
    enter_reset();
    p[0] = 8'h51; p[1] = 8'h2F; p[2] = 8'hF0; p[15] = 8'h02;
    load_all(p);
    run(cyc);
    chk("R2 cycles LDI+ADD+HLT", cyc, 14);

    // R2/R1: LDA takes 5 clocks, high nibble of memory ignored
    enter_reset();
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h1A; p[1] = 8'hE0; p[2] = 8'hF0; p[10] = 8'hC7;
    load_all(p);
    run(cyc);
    chk("R1 LDA low nibble", int'(out_val), 7);
    chk("R2 cycles LDA+OUT+HLT", cyc, 13);

    // R5: store, reset, reload stored word
    enter_reset();
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h59; p[1] = 8'h4C; p[2] = 8'hF0; p[12] = 8'h00;
    load_all(p);
    run(cyc);
    chk("R2 cycles LDI+STA+HLT", cyc, 13);
    enter_reset();
    poke(0, 8'h1C); poke(1, 8'hE0); poke(2, 8'hF0);
    run(cyc);
    chk("R5 stored value kept over reset", int'(out_val), 9);

    // R6: JMP skips code
    enter_reset();
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h65; p[1] = 8'h51; p[2] = 8'hE0; p[3] = 8'hF0;
    p[5] = 8'h56; p[6] = 8'hE0; p[7] = 8'hF0;
    load_all(p);
    run(cyc);
    chk("R6 JMP target", int'(out_val), 6);

    // R7: PC wraps 15 -> 0
    enter_reset();
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h74; p[1] = 8'h5F; p[2] = 8'h2C; p[3] = 8'h6E;
    p[4] = 8'hE0; p[5] = 8'hF0; p[12] = 8'h01; p[14] = 8'h58; p[15] = 8'h00;
    load_all(p);
    run(cyc);
    chk("R7 wrap reached loc 0 again", int'(out_val), 8);

    // R10: NOP and reserved codes have no effect
    enter_reset();
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h54; p[1] = 8'h03; p[2] = 8'hC9; p[3] = 8'hD9;
    p[4] = 8'hE0; p[5] = 8'hF0;
    load_all(p);
    run(cyc);
    chk("R10 A kept across NOP/C/D", int'(out_val), 4);
    chk("R10 cycles of NOP/C/D", cyc, 24);

    // R9: frozen after HLT; R11: load port ignored while running
    enter_reset();
    for (int i = 0; i < 16; i++) p[i] = 8'hF0;
    p[0] = 8'h57; p[1] = 8'hE0; p[2] = 8'hF0; p[3] = 8'h52; p[4] = 8'hE0;
    load_all(p);
    run(cyc);
    poke(0, 8'h53);
    repeat (40) @(negedge clk);
    chk("R9 display frozen after HLT", int'(out_val), 7);
    chk("R9 halted held", int'(halted), 1);
    enter_reset();
    chk("R12 reset clears display", int'(out_val), 0);
    chk("R12 reset clears halted", int'(halted), 0);
    run(cyc);
    chk("R11 run-time write ignored", int'(out_val), 7);

    // R3/R4/R6: sweep ALU ops over all operand pairs
    for (int k = 0; k < 5; k++) begin
      int op;
      op = (k < 2) ? k + 2 : k + 7;
      enter_reset();
      poke(2, 8'hE0); poke(4, 8'h87); poke(5, 8'h50); poke(6, 8'h6D);
      poke(7, 8'h51); poke(8, 8'h6D); poke(9, 8'h8C); poke(10, 8'h52);
      poke(11, 8'h6D); poke(12, 8'h53); poke(13, 8'hE0); poke(14, 8'hF0);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          enter_reset();
          poke(0, 8'h50 | a); poke(1, (op << 4) | 15); poke(15, b);
          poke(3, 8'hF0);
          run(cyc);
          chk("R3 result", int'(out_val), exp_res(op, a, b));
          enter_reset();
          poke(3, 8'h79);
          run(cyc);
          chk("R3/R4/R6 flag code via JC/JZ", int'(out_val), exp_code(op, a, b));
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule